// File: doc/BRIEF.md
# Inbound Request Error Response Handler

This block sits in the request path of a bridge that turns inbound PCIe memory requests into AXI master transactions. Each decoded request descriptor (direction, posted flag, poison flag, length in DW, first and last byte enables, requester tag) is classified when it is accepted. A clean request is forwarded to the AXI issue port. A poisoned request is dropped and reported through an interrupt strobe. A zero-byte request is answered locally, with no bus access.

For every forwarded request the block keeps the tag and the posted flag in an in-order outstanding queue. When the AXI response code comes back, the block pairs it with the oldest entry. It raises the matching error strobe and, for a non-posted request, emits a completion descriptor that carries the PCIe completion status and the original tag. Downstream logic builds and serializes the completion packet from this descriptor, and an interrupt register file latches the strobes.

Top module: `brg_err_resp`

## Requirements
- R1: An AXI response of code 2'b11 (decode error) raises `irq_decerr_o` for exactly the one cycle after the response is presented. No request is issued again for it.
- R2: When a decode error answers a non-posted request, a completion with status 3'b001 (unsupported request) and that request's tag is emitted. A posted request gets no completion.
- R3: An AXI response of code 2'b10 (slave error) raises `irq_slverr_o` for the one cycle after the response. No completion is emitted for a posted request.
- R4: When a slave error answers a non-posted request, a completion with status 3'b100 (completer abort) and that request's tag is emitted.
- R5: An AXI response of code 2'b00 or 2'b01 emits a completion with status 3'b000 (successful) for a non-posted request, and nothing for a posted one. It raises no interrupt.
- R6: An accepted request with the poison flag set is never issued on the AXI port. It raises `irq_poison_o` in the next cycle and produces no completion. Poison takes priority over the zero-length rule.
- R7: An accepted read with length 1 and both byte enables 4'b0000 is not issued on the AXI port. It yields a status 3'b000 completion with its tag in the next cycle.
- R8: An accepted write with length 1 and both byte enables 4'b0000 is not issued. It produces no completion and no interrupt.
- R9: `req_ready_o` is high exactly when the outstanding queue holds fewer than OUTS_DEPTH entries, `axi_req_ready_i` is high and `axi_rsp_valid_i` is low. A forwarded request shows `axi_req_valid_o` with its tag and direction in the cycle it is accepted.
- R10: Responses are matched to forwarded requests in issue order, so every response-driven completion carries the tag of the oldest unanswered request.
- R11: During and straight after reset, all strobes and `cpl_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request descriptor valid |
| req_ready_o | output | 1 | Request descriptor accepted this cycle when valid |
| req_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_posted_i | input | 1 | Request expects no completion |
| req_poison_i | input | 1 | Poison flag from the header |
| req_len_i | input | LEN_W | Length in DW |
| req_first_be_i | input | 4 | First DW byte enables |
| req_last_be_i | input | 4 | Last DW byte enables |
| req_tag_i | input | TAG_W | Requester tag |
| axi_req_valid_o | output | 1 | Forwarded request issued to AXI this cycle |
| axi_req_ready_i | input | 1 | AXI issue side can take a request |
| axi_req_write_o | output | 1 | Direction of the forwarded request |
| axi_req_tag_o | output | TAG_W | Tag of the forwarded request |
| axi_rsp_valid_i | input | 1 | AXI response code valid |
| axi_rsp_code_i | input | 2 | AXI response code |
| cpl_valid_o | output | 1 | Completion descriptor valid, one cycle |
| cpl_status_o | output | 3 | Completion status code |
| cpl_tag_o | output | TAG_W | Tag of the completed request |
| irq_decerr_o | output | 1 | Decode error strobe |
| irq_slverr_o | output | 1 | Slave error strobe |
| irq_poison_o | output | 1 | Poisoned request strobe |

## Verification
The ready and AXI issue outputs are combinational, so the bench checks them in the same cycle it drives a request. It does this a nanosecond after driving, before the next rising edge. Completions and strobes come from one register stage. They are due at the first rising edge after the request or response is presented, and the bench samples them one nanosecond after that edge. It then compares them against a queue model of the forwarded tags and posted flags. Because each check looks at exactly one cycle, a strobe that lasts too long or arrives late is reported as a miscompare.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

  typedef enum logic [2:0] {
    CPL_SC = 3'b000,
    CPL_UR = 3'b001,
    CPL_CA = 3'b100
  } cpl_status_e;

  typedef enum logic [1:0] {
    AXI_OKAY   = 2'b00,
    AXI_EXOKAY = 2'b01,
    AXI_SLVERR = 2'b10,
    AXI_DECERR = 2'b11
  } axi_resp_e;

  typedef enum logic [1:0] {
    REQ_FWD,
    REQ_POISON,
    REQ_ZL_READ,
    REQ_ZL_WRITE
  } req_class_e;

endpackage

// File: rtl/brg_req_classify.sv
module brg_req_classify
  import brg_err_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             write_i,
  input  logic             poison_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [3:0]       first_be_i,
  input  logic [3:0]       last_be_i,
  output req_class_e       class_o
);

  localparam logic [LEN_W-1:0] ONE_DW = LEN_W'(1);

  logic zero_len;
  assign zero_len = (len_i == ONE_DW) && (first_be_i == 4'b0) && (last_be_i == 4'b0);

  // poison wins over zero-length
  always_comb begin
    if (poison_i)      class_o = REQ_POISON;
    else if (zero_len) class_o = write_i ? REQ_ZL_WRITE : REQ_ZL_READ;
    else               class_o = REQ_FWD;
  end

endmodule

// File: rtl/brg_outs_fifo.sv
module brg_outs_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                      push_i |-> !full_o);  // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
                      pop_i |-> !empty_o);  // R10

endmodule

// File: rtl/brg_rsp_map.sv
module brg_rsp_map
  import brg_err_pkg::*;
(
  input  logic [1:0]  code_i,
  input  logic        posted_i,
  output logic        cpl_en_o,
  output cpl_status_e status_o,
  output logic        decerr_o,
  output logic        slverr_o
);

  always_comb begin
    decerr_o = 1'b0;
    slverr_o = 1'b0;
    status_o = CPL_SC;
    unique case (axi_resp_e'(code_i))
      AXI_DECERR: begin decerr_o = 1'b1; status_o = CPL_UR; end
      AXI_SLVERR: begin slverr_o = 1'b1; status_o = CPL_CA; end
      default:    status_o = CPL_SC;
    endcase
    cpl_en_o = !posted_i;
  end

endmodule

// File: rtl/brg_err_resp.sv
module brg_err_resp
  import brg_err_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int LEN_W      = 10,
  parameter int OUTS_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_posted_i,
  input  logic             req_poison_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [3:0]       req_first_be_i,
  input  logic [3:0]       req_last_be_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             axi_req_valid_o,
  input  logic             axi_req_ready_i,
  output logic             axi_req_write_o,
  output logic [TAG_W-1:0] axi_req_tag_o,
  input  logic             axi_rsp_valid_i,
  input  logic [1:0]       axi_rsp_code_i,
  output logic             cpl_valid_o,
  output logic [2:0]       cpl_status_o,
  output logic [TAG_W-1:0] cpl_tag_o,
  output logic             irq_decerr_o,
  output logic             irq_slverr_o,
  output logic             irq_poison_o
);

  localparam int ENT_W = TAG_W + 1;

  req_class_e       req_class;
  logic             accept;
  logic             q_full, q_empty;
  logic [ENT_W-1:0] q_head;
  logic [TAG_W-1:0] head_tag;
  logic             head_posted;
  logic             map_cpl_en, map_dec, map_slv;
  cpl_status_e      map_status;

  logic             cpl_valid_d, irq_dec_d, irq_slv_d, irq_poi_d;
  logic [2:0]       cpl_status_d;
  logic [TAG_W-1:0] cpl_tag_d;

  brg_req_classify #(.LEN_W(LEN_W)) u_classify (
    .write_i    (req_write_i),
    .poison_i   (req_poison_i),
    .len_i      (req_len_i),
    .first_be_i (req_first_be_i),
    .last_be_i  (req_last_be_i),
    .class_o    (req_class)
  );

  // a response cycle blocks intake so only one completion source is live
  assign req_ready_o     = !q_full && axi_req_ready_i && !axi_rsp_valid_i;
  assign accept          = req_valid_i && req_ready_o;
  assign axi_req_valid_o = accept && (req_class == REQ_FWD);
  assign axi_req_write_o = req_write_i;
  assign axi_req_tag_o   = req_tag_i;

  brg_outs_fifo #(.WIDTH(ENT_W), .DEPTH(OUTS_DEPTH)) u_outs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (axi_req_valid_o),
    .data_i  ({req_tag_i, req_posted_i}),
    .pop_i   (axi_rsp_valid_i),
    .data_o  (q_head),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  assign head_tag    = q_head[ENT_W-1:1];
  assign head_posted = q_head[0];

  brg_rsp_map u_map (
    .code_i   (axi_rsp_code_i),
    .posted_i (head_posted),
    .cpl_en_o (map_cpl_en),
    .status_o (map_status),
    .decerr_o (map_dec),
    .slverr_o (map_slv)
  );

  always_comb begin
    cpl_valid_d  = 1'b0;
    cpl_status_d = CPL_SC;
    cpl_tag_d    = '0;
    irq_dec_d    = 1'b0;
    irq_slv_d    = 1'b0;
    irq_poi_d    = accept && (req_class == REQ_POISON);
    if (axi_rsp_valid_i) begin
      cpl_valid_d  = map_cpl_en;
      cpl_status_d = map_status;
      cpl_tag_d    = head_tag;
      irq_dec_d    = map_dec;
      irq_slv_d    = map_slv;
    end else if (accept && (req_class == REQ_ZL_READ)) begin
      cpl_valid_d  = 1'b1;
      cpl_status_d = CPL_SC;
      cpl_tag_d    = req_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_valid_o  <= 1'b0;
      cpl_status_o <= CPL_SC;
      cpl_tag_o    <= '0;
      irq_decerr_o <= 1'b0;
      irq_slverr_o <= 1'b0;
      irq_poison_o <= 1'b0;
    end else begin
      cpl_valid_o  <= cpl_valid_d;
      cpl_status_o <= cpl_status_d;
      cpl_tag_o    <= cpl_tag_d;
      irq_decerr_o <= irq_dec_d;
      irq_slverr_o <= irq_slv_d;
      irq_poison_o <= irq_poi_d;
    end
  end

  AST_DECERR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (axi_rsp_valid_i && axi_rsp_code_i == 2'b11) |=> irq_decerr_o);  // R1
  AST_SLVERR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (axi_rsp_valid_i && axi_rsp_code_i == 2'b10) |=> irq_slverr_o);  // R3
  AST_POISON_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_poison_i) |-> !axi_req_valid_o);  // R6
  AST_POISON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && req_poison_i) |=> (irq_poison_o && !cpl_valid_o));  // R6
  AST_ZL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_len_i == LEN_W'(1) && req_first_be_i == 4'b0
       && req_last_be_i == 4'b0) |-> !axi_req_valid_o);  // R7
  AST_RSP_STALLS_INTAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      axi_rsp_valid_i |-> !req_ready_o);  // R9
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({irq_decerr_o, irq_slverr_o, irq_poison_o}));  // R1
  AST_RSP_NEEDS_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      axi_rsp_valid_i |-> !q_empty);  // R10

endmodule

// File: tb/brg_err_resp_tb.sv
`timescale 1ns/1ps
module brg_err_resp_tb;

  localparam int TAG_W = 8;
  localparam int LEN_W = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid, req_write, req_posted, req_poison;
  logic [LEN_W-1:0] req_len;
  logic [3:0]       req_fbe, req_lbe;
  logic [TAG_W-1:0] req_tag;
  logic             axi_rdy, rsp_valid;
  logic [1:0]       rsp_code;
  logic             req_ready, axi_valid, axi_write;
  logic [TAG_W-1:0] axi_tag, cpl_tag;
  logic             cpl_valid, irq_dec, irq_slv, irq_poi;
  logic [2:0]       cpl_status;

  brg_err_resp #(.TAG_W(TAG_W), .LEN_W(LEN_W), .OUTS_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_posted_i(req_posted), .req_poison_i(req_poison), .req_len_i(req_len),
    .req_first_be_i(req_fbe), .req_last_be_i(req_lbe), .req_tag_i(req_tag),
    .axi_req_valid_o(axi_valid), .axi_req_ready_i(axi_rdy),
    .axi_req_write_o(axi_write), .axi_req_tag_o(axi_tag),
    .axi_rsp_valid_i(rsp_valid), .axi_rsp_code_i(rsp_code),
    .cpl_valid_o(cpl_valid), .cpl_status_o(cpl_status), .cpl_tag_o(cpl_tag),
    .irq_decerr_o(irq_dec), .irq_slverr_o(irq_slv), .irq_poison_o(irq_poi)
  );

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [TAG_W-1:0] m_tag  [16];
  logic             m_post [16];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit is_zl(input logic [LEN_W-1:0] l, input logic [3:0] f, input logic [3:0] b);
    return (l == 1) && (f == 4'b0) && (b == 4'b0);
  endfunction

  // one cycle: drive, check issue side, then registered results
  task automatic step(input bit v, input bit w, input bit p, input bit pz,
                      input logic [LEN_W-1:0] l, input logic [3:0] f, input logic [3:0] b,
                      input logic [TAG_W-1:0] t, input bit ar, input bit rv, input logic [1:0] rc);
    bit e_rdy, e_fwd, acc;
    bit e_cpl, e_dec, e_slv, e_poi;
    logic [2:0] e_st;
    logic [TAG_W-1:0] e_tag;
    @(negedge clk);
    req_valid = v; req_write = w; req_posted = p; req_poison = pz;
    req_len = l; req_fbe = f; req_lbe = b; req_tag = t;
    axi_rdy = ar; rsp_valid = rv; rsp_code = rc;
    #1;
    e_rdy = (m_cnt < DEPTH) && ar && !rv;
    acc   = v && e_rdy;
    e_fwd = acc && !pz && !is_zl(l, f, b);
    chk("R9", "req_ready", req_ready, e_rdy);
    chk("R9", "axi_valid", axi_valid, e_fwd);
    if (e_fwd) begin
      chk("R9", "axi_tag", axi_tag, t);
      chk("R9", "axi_write", axi_write, w);
    end
    e_cpl = 0; e_dec = 0; e_slv = 0; e_poi = 0; e_st = 3'b000; e_tag = '0;
    if (rv) begin
      e_tag = m_tag[m_head];
      e_cpl = !m_post[m_head];
      e_dec = (rc == 2'b11);
      e_slv = (rc == 2'b10);
      e_st  = e_dec ? 3'b001 : e_slv ? 3'b100 : 3'b000;
      m_head = (m_head + 1) % 16; m_cnt--;
    end else if (acc) begin
      if (pz) e_poi = 1;
      else if (is_zl(l, f, b) && !w) begin e_cpl = 1; e_tag = t; end
    end
    if (e_fwd) begin
      m_tag[m_tail] = t; m_post[m_tail] = p;
      m_tail = (m_tail + 1) % 16; m_cnt++;
    end
    @(posedge clk); #1;
    chk(rv ? (rc == 2'b11 ? "R1" : rc == 2'b10 ? "R3" : "R5") : "R6", "irq_decerr", irq_dec, e_dec);
    chk(rv ? "R3" : "R8", "irq_slverr", irq_slv, e_slv);
    chk(pz ? "R6" : "R8", "irq_poison", irq_poi, e_poi);
    chk(rv ? "R2" : "R7", "cpl_valid", cpl_valid, e_cpl);
    if (e_cpl) begin
      chk(rv ? (rc == 2'b11 ? "R2" : rc == 2'b10 ? "R4" : "R5") : "R7", "cpl_status", cpl_status, e_st);
      chk("R10", "cpl_tag", cpl_tag, e_tag);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 10'd4, 4'hf, 4'hf, 8'h00, 1, 0, 2'b00);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    req_valid = 0; req_write = 0; req_posted = 0; req_poison = 0;
    req_len = '0; req_fbe = '0; req_lbe = '0; req_tag = '0;
    axi_rdy = 0; rsp_valid = 0; rsp_code = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "cpl_valid", cpl_valid, 0);
    chk("R11", "irqs", {irq_dec, irq_slv, irq_poi}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R11", "cpl_valid post", cpl_valid, 0);
    chk("R11", "irqs post", {irq_dec, irq_slv, irq_poi}, 3'b000);

    // R1 R2: non-posted read + decode error
    step(1, 0, 0, 0, 10'd8, 4'hf, 4'hf, 8'h11, 1, 0, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b11);
    // R3: posted write + slave error
    step(1, 1, 1, 0, 10'd2, 4'hf, 4'h3, 8'h22, 1, 0, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b10);
    // R4: non-posted read + slave error
    step(1, 0, 0, 0, 10'd1, 4'h1, 4'h0, 8'h33, 1, 0, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b10);
    // R1: posted write + decode error, no completion
    step(1, 1, 1, 0, 10'd3, 4'hf, 4'hf, 8'h44, 1, 0, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b11);
    // R5: OKAY and EXOKAY
    step(1, 0, 0, 0, 10'd5, 4'hf, 4'hf, 8'h55, 1, 0, 2'b00);
    step(1, 0, 0, 0, 10'd5, 4'hf, 4'hf, 8'h56, 1, 0, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b00);
    step(0, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h00, 1, 1, 2'b01);
    // R6: poisoned read, poisoned zero-length read
    step(1, 0, 0, 1, 10'd4, 4'hf, 4'hf, 8'h66, 1, 0, 2'b00);
    step(1, 0, 0, 1, 10'd1, 4'h0, 4'h0, 8'h67, 1, 0, 2'b00);
    // R7 R8: zero-length read and write
    step(1, 0, 0, 0, 10'd1, 4'h0, 4'h0, 8'h77, 1, 0, 2'b00);
    step(1, 1, 1, 0, 10'd1, 4'h0, 4'h0, 8'h78, 1, 0, 2'b00);
    idle();
    // R9 R10: fill queue, stall, drain in order
    for (int i = 0; i < DEPTH; i++)
      step(1, i[0], i[0], 0, 10'd2, 4'hf, 4'hf, 8'h80 + 8'(i), 1, 0, 2'b00);
    step(1, 0, 0, 0, 10'd2, 4'hf, 4'hf, 8'h90, 1, 0, 2'b00);
    step(1, 0, 0, 0, 10'd2, 4'hf, 4'hf, 8'h91, 1, 1, 2'b11);
    step(1, 0, 0, 0, 10'd2, 4'hf, 4'hf, 8'h92, 0, 0, 2'b00);
    for (int i = 1; i < DEPTH; i++)
      step(0, 0, 0, 0, 10'd2, 4'hf, 4'hf, 8'h00, 1, 1, 2'(i));

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit w, rv;
      logic [LEN_W-1:0] l;
      logic [3:0] f, b;
      w = $urandom % 2;
      l = ($urandom % 3 == 0) ? LEN_W'(1) : LEN_W'($urandom % 1024);
      f = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
      b = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
      rv = (m_cnt > 0) && ($urandom % 3 == 0);
      step($urandom % 4 != 0, w, w && ($urandom % 4 != 0), $urandom % 8 == 0, l, f, b,
           8'($urandom), $urandom % 5 != 0, rv, 2'($urandom));
    end
    while (m_cnt > 0) step(0, 0, 0, 0, 10'd2, 4'hf, 4'hf, 8'h00, 1, 1, 2'($urandom));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule